// File: doc/BRIEF.md
# Status Flag Set/Clear Unit

This block owns the processor's condition-code status word and carries out the two flag-manipulation instructions: one that ORs an immediate mask into the status word and one that removes the mask's bits from it. It also carries out two related operations. A memory-operand arithmetic instruction first drops the carry and overflow bits. Any other instruction drops the extend bit. Every update lands on a single rising clock edge.

The block also holds the stack pointer and a kernel stack-pointer register. When a set-flags instruction runs in supervisor mode and its mask contains the user-mode bit, the block saves the live stack pointer into the kernel copy and loads the stack pointer from the user stack-pointer value on `usp_i`. In the next cycle it pulses `flush_o` so that the fetch stage re-evaluates the instruction flow under the new privilege. The current mode is the user-mode bit of the status word. A normal register-file write to the stack pointer comes in on a separate write port.

Top module: `sfu_top`

## Requirements
- R1: While `rst_ni` is low, `ccs_o`, `sp_o` and `ksp_o` are zero and `flush_o` is low, which puts the core in supervisor mode.
- R2: With `op_vld_i` high and `op_i`=0 (set), the status word becomes its previous value OR `mask_i` at the next edge.
- R3: With `op_vld_i` high and `op_i`=1 (clear), the status word becomes its previous value AND the inverse of `mask_i` at the next edge.
- R4: A set operation whose mask has bit 6 (user) set while status bit 6 is 0 loads `ksp_o` with the old `sp_o` and loads `sp_o` with `usp_i` at the next edge. `flush_o` is high for exactly that following cycle.
- R5: A set operation with mask bit 6 set while status bit 6 is already 1 leaves `sp_o` and `ksp_o` unchanged and does not raise `flush_o`.
- R6: A clear operation that clears bit 6 swaps no stack pointers and raises no flush.
- R7: Set and clear leave the extend flag (bit 4) as their mask dictates. Any other valid operation (`op_i`=3) clears bit 4 and keeps all other bits.
- R8: `op_i`=2 (memory-operand arithmetic) clears bits 0 (carry) and 1 (overflow) and keeps all other bits.
- R9: `sp_we_i` loads `sp_o` from `sp_wdata_i` at the next edge, except that a user-mode entry in the same cycle takes priority.
- R10: With `op_vld_i` low, the status word holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| op_vld_i | input | 1 | An operation is issued this cycle |
| op_i | input | 2 | 0 set, 1 clear, 2 memory-arith, 3 other |
| mask_i | input | FLAG_W | Immediate flag mask |
| usp_i | input | SP_W | User stack-pointer value |
| sp_we_i | input | 1 | Normal stack-pointer write enable |
| sp_wdata_i | input | SP_W | Normal stack-pointer write data |
| ccs_o | output | FLAG_W | Status word |
| sp_o | output | SP_W | Current stack pointer |
| ksp_o | output | SP_W | Saved kernel stack pointer |
| user_mode_o | output | 1 | Status bit 6 |
| flush_o | output | 1 | Flow-redirect request after a user-mode entry |

## Verification
The assertions check on every cycle that the status update follows the mask for each operation kind, that an idle cycle holds the status word, that every user entry swaps both stack registers, and that a flush appears only in the cycle after an entry. The bench's scenarios are needed to show ordering effects across several instructions. These include a second set of the user bit that must not swap again, a clear of the user bit followed by a re-entry, and a register write that loses to a swap in the same cycle. A long random stream, compared cycle by cycle against a behavioural model, covers the combinations that the directed steps do not reach.

// File: rtl/sfu_pkg.sv
package sfu_pkg;
  typedef enum logic [1:0] {
    OP_SET   = 2'd0,
    OP_CLR   = 2'd1,
    OP_MEMCV = 2'd2,
    OP_OTHER = 2'd3
  } sfu_op_e;
endpackage

// File: rtl/sfu_ccs_next.sv
module sfu_ccs_next
  import sfu_pkg::*;
#(
  parameter int FLAG_W = 16,
  parameter int U_BIT  = 6,
  parameter int X_BIT  = 4
) (
  input  logic              vld_i,
  input  logic [1:0]        op_i,
  input  logic [FLAG_W-1:0] mask_i,
  input  logic [FLAG_W-1:0] ccs_q_i,
  output logic [FLAG_W-1:0] ccs_d_o,
  output logic              enter_user_o
);
  localparam logic [FLAG_W-1:0] CV_MASK = FLAG_W'(3);
  localparam logic [FLAG_W-1:0] X_MASK  = FLAG_W'(1) << X_BIT;

  sfu_op_e op;
  assign op = sfu_op_e'(op_i);

  always_comb begin
    ccs_d_o = ccs_q_i;
    if (vld_i) begin
      unique case (op)
        OP_SET:   ccs_d_o = ccs_q_i | mask_i;
        OP_CLR:   ccs_d_o = ccs_q_i & ~mask_i;
        OP_MEMCV: ccs_d_o = ccs_q_i & ~CV_MASK;
        OP_OTHER: ccs_d_o = ccs_q_i & ~X_MASK;
        default:  ccs_d_o = ccs_q_i;
      endcase
    end
  end

  // supervisor -> user transition only
  assign enter_user_o = vld_i && (op == OP_SET) && mask_i[U_BIT] && !ccs_q_i[U_BIT];
endmodule

// File: rtl/sfu_stack_swap.sv
module sfu_stack_swap #(
  parameter int SP_W = 32
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            swap_i,
  input  logic [SP_W-1:0] usp_i,
  input  logic            we_i,
  input  logic [SP_W-1:0] wdata_i,
  output logic [SP_W-1:0] sp_o,
  output logic [SP_W-1:0] ksp_o
);
  logic [SP_W-1:0] sp_q, ksp_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sp_q  <= '0;
      ksp_q <= '0;
    end else if (swap_i) begin
      ksp_q <= sp_q;
      sp_q  <= usp_i;
    end else if (we_i) begin
      sp_q  <= wdata_i;
    end
  end

  assign sp_o  = sp_q;
  assign ksp_o = ksp_q;
endmodule

// File: rtl/sfu_top.sv
module sfu_top #(
  parameter int FLAG_W = 16,
  parameter int SP_W   = 32,
  parameter int U_BIT  = 6,
  parameter int X_BIT  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              op_vld_i,
  input  logic [1:0]        op_i,
  input  logic [FLAG_W-1:0] mask_i,
  input  logic [SP_W-1:0]   usp_i,
  input  logic              sp_we_i,
  input  logic [SP_W-1:0]   sp_wdata_i,
  output logic [FLAG_W-1:0] ccs_o,
  output logic [SP_W-1:0]   sp_o,
  output logic [SP_W-1:0]   ksp_o,
  output logic              user_mode_o,
  output logic              flush_o
);
  logic [FLAG_W-1:0] ccs_q, ccs_d;
  logic              enter_user;
  logic              flush_q;

  sfu_ccs_next #(.FLAG_W(FLAG_W), .U_BIT(U_BIT), .X_BIT(X_BIT)) u_next (
    .vld_i        (op_vld_i),
    .op_i         (op_i),
    .mask_i       (mask_i),
    .ccs_q_i      (ccs_q),
    .ccs_d_o      (ccs_d),
    .enter_user_o (enter_user)
  );

  sfu_stack_swap #(.SP_W(SP_W)) u_stk (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .swap_i  (enter_user),
    .usp_i   (usp_i),
    .we_i    (sp_we_i),
    .wdata_i (sp_wdata_i),
    .sp_o    (sp_o),
    .ksp_o   (ksp_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ccs_q   <= '0;
      flush_q <= 1'b0;
    end else begin
      ccs_q   <= ccs_d;
      flush_q <= enter_user;
    end
  end

  assign ccs_o       = ccs_q;
  assign user_mode_o = ccs_q[U_BIT];
  assign flush_o     = flush_q;
endmodule

// File: rtl/sfu_chk.sv
module sfu_chk #(
  parameter int FLAG_W = 16,
  parameter int SP_W   = 32,
  parameter int U_BIT  = 6,
  parameter int X_BIT  = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              op_vld_i,
  input logic [1:0]        op_i,
  input logic [FLAG_W-1:0] mask_i,
  input logic [SP_W-1:0]   usp_i,
  input logic [FLAG_W-1:0] ccs_o,
  input logic [SP_W-1:0]   sp_o,
  input logic [SP_W-1:0]   ksp_o,
  input logic              flush_o
);
  logic entry;
  assign entry = op_vld_i && op_i == 2'd0 && mask_i[U_BIT] && !ccs_o[U_BIT];

  // R2
  setf_or_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_vld_i && op_i == 2'd0) |=> ccs_o == ($past(ccs_o) | $past(mask_i)));
  // R3
  clrf_and_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_vld_i && op_i == 2'd1) |=> ccs_o == ($past(ccs_o) & ~$past(mask_i)));
  // R4
  user_entry_swap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    entry |=> (sp_o == $past(usp_i) && ksp_o == $past(sp_o) && flush_o));
  // R5
  flush_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !entry |=> !flush_o);
  // R8
  memclr_cv_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_vld_i && op_i == 2'd2) |=> ccs_o == ($past(ccs_o) & ~FLAG_W'(3)));
  // R7
  other_x_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_vld_i && op_i == 2'd3) |=> ccs_o == ($past(ccs_o) & ~(FLAG_W'(1) << X_BIT)));
  // R10
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !op_vld_i |=> $stable(ccs_o));
endmodule

bind sfu_top sfu_chk #(.FLAG_W(FLAG_W), .SP_W(SP_W), .U_BIT(U_BIT), .X_BIT(X_BIT)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .op_vld_i (op_vld_i),
  .op_i     (op_i),
  .mask_i   (mask_i),
  .usp_i    (usp_i),
  .ccs_o    (ccs_o),
  .sp_o     (sp_o),
  .ksp_o    (ksp_o),
  .flush_o  (flush_o)
);

// File: tb/sim_sfu_top.sv
`timescale 1ns/1ps
module sim_sfu_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        op_vld_i = 1'b0;
  logic [1:0]  op_i = '0;
  logic [15:0] mask_i = '0;
  logic [31:0] usp_i = '0;
  logic        sp_we_i = 1'b0;
  logic [31:0] sp_wdata_i = '0;
  logic [15:0] ccs_o;
  logic [31:0] sp_o, ksp_o;
  logic        user_mode_o, flush_o;

  int total = 0;
  int bad = 0;

  // reference state
  int unsigned m_ccs = 0, m_sp = 0, m_ksp = 0;
  bit m_flush = 0;

  always #2 clk_i = ~clk_i;

  sfu_top u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .op_vld_i(op_vld_i), .op_i(op_i),
    .mask_i(mask_i), .usp_i(usp_i), .sp_we_i(sp_we_i), .sp_wdata_i(sp_wdata_i),
    .ccs_o(ccs_o), .sp_o(sp_o), .ksp_o(ksp_o), .user_mode_o(user_mode_o),
    .flush_o(flush_o)
  );

  task automatic chk(string tag, string what, longint unsigned act, longint unsigned exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic compare(string tag);
    chk(tag, "ccs", ccs_o, m_ccs);
    chk(tag, "sp", sp_o, m_sp);
    chk(tag, "ksp", ksp_o, m_ksp);
    chk(tag, "flush", flush_o, m_flush);
    chk(tag, "umode", user_mode_o, (m_ccs >> 6) & 1);
  endtask

  task automatic step(string tag, bit v, int op, int unsigned m, int unsigned u,
                      bit we, int unsigned wd);
    bit enter;
    op_vld_i = v; op_i = 2'(op); mask_i = 16'(m); usp_i = u;
    sp_we_i = we; sp_wdata_i = wd;
    enter = v && op == 0 && ((m >> 6) & 1) && !((m_ccs >> 6) & 1);
    m_flush = enter;
    if (enter) begin
      m_ksp = m_sp;
      m_sp  = u;
    end else if (we) begin
      m_sp = wd;
    end
    if (v) begin
      case (op)
        0: m_ccs = m_ccs | m;
        1: m_ccs = m_ccs & ~m;
        2: m_ccs = m_ccs & ~32'h3;
        default: m_ccs = m_ccs & ~32'h10;
      endcase
    end
    m_ccs = m_ccs & 32'hFFFF;
    @(posedge clk_i);
    @(negedge clk_i);
    compare(tag);
  endtask

  initial begin
    #(4 * 150000);
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    @(negedge clk_i);
    @(negedge clk_i);
    compare("R1");
    rst_ni = 1'b1;
    step("R10", 0, 0, 16'hFFFF, 0, 0, 0);
    step("R2", 1, 0, 16'h0005, 0, 0, 0);
    step("R7", 1, 0, 16'h0010, 0, 0, 0);
    step("R7", 1, 3, 16'hFFFF, 0, 0, 0);
    step("R3", 1, 1, 16'h0001, 0, 0, 0);
    step("R9", 0, 0, 0, 0, 1, 32'h1000);
    step("R8", 1, 0, 16'h000F, 0, 0, 0);
    step("R8", 1, 2, 16'h0000, 0, 0, 0);
    step("R4", 1, 0, 16'h0040, 32'hBEEF0000, 0, 0);
    step("R4", 0, 0, 0, 0, 0, 0);
    step("R5", 1, 0, 16'h0040, 32'h12345678, 0, 0);
    step("R6", 1, 1, 16'h0040, 32'h55555555, 0, 0);
    step("R9", 1, 0, 16'h0041, 32'hCAFE0000, 1, 32'h2222);
    step("R10", 0, 1, 16'hFFFF, 0, 0, 0);
    for (int i = 0; i < 400; i++) begin
      int unsigned r;
      r = $urandom;
      step("RND", r[0] | r[1], int'(r[3:2]), $urandom & 16'hFFFF,
           $urandom, r[4], $urandom);
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule